// File: doc/BRIEF.md
# Host-to-Coprocessor Control Bridge

This block sits on the bus of a small 8-bit host processor and gives that host control over a 16-bit coprocessor. The host and the coprocessor exchange bytes through four shared mailbox registers. The host loads program or data bytes into the coprocessor's 1 MiB memory through an address latch and a data port that steps through memory. It also drives a control byte that halts the coprocessor, pulses its reset line, raises its interrupt and sets the overlay visibility bit, which the coprocessor can set as well.

Every host-visible register stays inert until the host writes a fixed 8-byte key, one byte per write, anywhere in the host window 0x1C00-0x1FFF. Until then host writes to the registers have no effect and host reads return zero. After the key is matched the bridge stays open until reset. Arbitration of the coprocessor memory between the two processors lies outside this block. The block only issues write strobes and reports ownership through the halt output.

Top module: `cop_host_bridge`

## Requirements
- R1: In reset and afterwards, until the host first writes the control register, the block behaves as if control byte 0x03 had been written: `cop_halt`=1, `cop_irq`=0, `overlay_en`=0, `ram_we`=0. `cop_reset` is 1 during reset and 0 from the first cycle after reset is released.
- R2: While the bridge is locked, host writes to offsets 0x1FF0-0x1FF7 change no state, and every host read returns 0x00.
- R3: The bridge unlocks after the bytes 0x47, 0x6E, 0x31, 0x14, 0xB3, 0xEB, 0xEC, 0x2B are written in that order to host addresses in 0x1C00-0x1FFF. Writes outside that window are not observed. A wrong byte resets the match, or leaves it at step 1 if that byte is 0x47. Once unlocked, the bridge stays unlocked until reset.
- R4: Host offset 0x1FF0+k (k=0..3) reads and writes mailbox k as one byte. On the coprocessor side, `cop_mb_sel` picks a mailbox. A write stores bits 7:0 of `cop_mb_wdata`. `cop_mb_rdata` shows the selected mailbox, zero-extended, one cycle after the select is presented.
- R5: When the host and the coprocessor write the same mailbox in the same cycle, the host byte is stored.
- R6: A write to 0x1FF4 stages address bits 11:4. A write to 0x1FF5 loads the 20-bit pointer as {data, staged byte, 4'b0000}. A write to 0x1FF4 alone does not move the pointer.
- R7: A write to 0x1FF6 while the host owns the memory produces, in the next cycle, one cycle of `ram_we` with `ram_addr` equal to the pointer and `ram_wdata` equal to the byte written. The pointer then increments and wraps from 0xFFFFF to 0x00000.
- R8: Control bit 0 (offset 0x1FF7) sets memory ownership, and `cop_halt` follows it one cycle after the write. While it is 0, data port writes produce no `ram_we` and leave the pointer unchanged.
- R9: Writing control with bit 1 set drives `cop_reset` high for exactly the one following cycle.
- R10: Writing control with bit 2 set raises `cop_irq`. It stays high until a cycle with `cop_irq_ack`=1. A set and an acknowledge in the same cycle leave it set.
- R11: Control bit 7 and the coprocessor's `cop_ovl_we`/`cop_ovl_d` write the single storage bit behind `overlay_en`, and the host wins a same-cycle conflict. A host read of 0x1FF7 returns {overlay bit, 6'b0, ownership bit}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 13 | Host byte address within its 8 KiB page |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, registered, valid the cycle after `host_rd` |
| cop_mb_sel | input | 2 | Coprocessor mailbox select |
| cop_mb_we | input | 1 | Coprocessor mailbox write strobe |
| cop_mb_wdata | input | 16 | Coprocessor mailbox write data, low byte stored |
| cop_mb_rdata | output | 16 | Selected mailbox, zero-extended, registered |
| cop_ovl_we | input | 1 | Coprocessor write strobe for the overlay bit |
| cop_ovl_d | input | 1 | Coprocessor overlay bit value |
| cop_irq_ack | input | 1 | Coprocessor interrupt acknowledge |
| ram_we | output | 1 | Coprocessor memory write strobe |
| ram_addr | output | 20 | Coprocessor memory byte address |
| ram_wdata | output | 8 | Coprocessor memory write byte |
| cop_halt | output | 1 | Host owns memory; coprocessor halted |
| cop_reset | output | 1 | Coprocessor reset pulse |
| cop_irq | output | 1 | Coprocessor interrupt request |
| overlay_en | output | 1 | Overlay visibility |

## Verification
The bench tries to break the key matcher. It sends a key that fails on its last byte, a key with a repeated first byte inside it, and a stray byte written outside the window. A matcher that does not reload on 0x47, or that watches every address, would stay locked or unlock too early. The bench drives same-cycle mailbox and overlay writes from both sides. A design with the wrong priority would keep the coprocessor's value. It checks that the address latch ignores a lone low-byte write, that the data port wraps at the top of memory, and that a write made while the host does not own the memory neither strobes nor advances the pointer. The bench also checks the widths of the reset and interrupt pulses against the acknowledge.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int HADDR_W  = 13;
  localparam int KEY_LEN  = 8;
  localparam logic [HADDR_W-1:0] OFF_MB0   = 13'h1FF0;
  localparam logic [HADDR_W-1:0] OFF_ALO   = 13'h1FF4;
  localparam logic [HADDR_W-1:0] OFF_AHI   = 13'h1FF5;
  localparam logic [HADDR_W-1:0] OFF_DATA  = 13'h1FF6;
  localparam logic [HADDR_W-1:0] OFF_CTRL  = 13'h1FF7;
  localparam logic [2:0]         WIN_TOP   = 3'b111;

  function automatic logic [7:0] hb_key(input int unsigned idx);
    case (idx)
      0: hb_key = 8'h47;
      1: hb_key = 8'h6E;
      2: hb_key = 8'h31;
      3: hb_key = 8'h14;
      4: hb_key = 8'hB3;
      5: hb_key = 8'hEB;
      6: hb_key = 8'hEC;
      7: hb_key = 8'h2B;
      default: hb_key = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/hb_unlock.sv
module hb_unlock #(
  parameter int KEY_LEN = 8,
  parameter int DW      = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          byte_we,
  input  logic [DW-1:0] byte_d,
  output logic          unlocked
);
  localparam int SW = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;
  localparam logic [SW-1:0] LAST = SW'(KEY_LEN - 1);

  logic [SW-1:0] step;
  logic          hit;
  logic          first_hit;

  always_comb begin
    hit       = (byte_d == hb_pkg::hb_key(int'(step)));
    first_hit = (byte_d == hb_pkg::hb_key(0));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step     <= '0;
      unlocked <= 1'b0;
    end else if (byte_we && !unlocked) begin
      if (hit) begin
        if (step == LAST) begin
          unlocked <= 1'b1;
          step     <= '0;
        end else begin
          step <= step + SW'(1);
        end
      end else begin
        step <= first_hit ? SW'(1) : '0;
      end
    end
  end
endmodule

// File: rtl/hb_mailbox.sv
module hb_mailbox #(
  parameter int N     = 4,
  parameter int W     = 8,
  parameter int COP_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 host_we,
  input  logic [$clog2(N)-1:0] host_idx,
  input  logic [W-1:0]         host_wdata,
  output logic [W-1:0]         host_rval,
  input  logic                 cop_we,
  input  logic [$clog2(N)-1:0] cop_idx,
  input  logic [COP_W-1:0]     cop_wdata,
  output logic [COP_W-1:0]     cop_rdata
);
  logic [W-1:0] box [N];

  for (genvar k = 0; k < N; k++) begin : g_box
    logic host_hit, cop_hit;
    assign host_hit = host_we && (host_idx == k);
    assign cop_hit  = cop_we  && (cop_idx  == k);
    always_ff @(posedge clk) begin
      if (rst)           box[k] <= '0;
      else if (host_hit) box[k] <= host_wdata;
      else if (cop_hit)  box[k] <= cop_wdata[W-1:0];
    end
  end

  assign host_rval = box[host_idx];

  always_ff @(posedge clk) begin
    if (rst) cop_rdata <= '0;
    else     cop_rdata <= COP_W'(box[cop_idx]);
  end
endmodule

// File: rtl/hb_loader.sv
module hb_loader #(
  parameter int AW = 20,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stage_we,
  input  logic          latch_we,
  input  logic          data_we,
  input  logic          own,
  input  logic [DW-1:0] wdata,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata
);
  localparam int LOW = AW - 2 * DW;

  logic [AW-1:0] ptr;
  logic [DW-1:0] staged;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr       <= '0;
      staged    <= '0;
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
    end else begin
      ram_we <= 1'b0;
      if (stage_we) staged <= wdata;
      if (latch_we) ptr <= {wdata, staged, {LOW{1'b0}}};
      if (data_we && own) begin
        ram_we    <= 1'b1;
        ram_addr  <= ptr;
        ram_wdata <= wdata;
        ptr       <= ptr + AW'(1);
      end
    end
  end
endmodule

// File: rtl/hb_ctrl.sv
module hb_ctrl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_we,
  input  logic [DW-1:0] wdata,
  input  logic          cop_ovl_we,
  input  logic          cop_ovl_d,
  input  logic          cop_irq_ack,
  output logic          own,
  output logic          ovl,
  output logic          cop_reset,
  output logic          cop_irq
);
  localparam int B_OWN = 0;
  localparam int B_RST = 1;
  localparam int B_IRQ = 2;
  localparam int B_OVL = DW - 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      own       <= 1'b1;
      ovl       <= 1'b0;
      cop_reset <= 1'b1;
      cop_irq   <= 1'b0;
    end else begin
      cop_reset <= host_we && wdata[B_RST];
      if (host_we) begin
        own <= wdata[B_OWN];
        ovl <= wdata[B_OVL];
      end else if (cop_ovl_we) begin
        ovl <= cop_ovl_d;
      end
      if (host_we && wdata[B_IRQ]) cop_irq <= 1'b1;
      else if (cop_irq_ack)        cop_irq <= 1'b0;
    end
  end
endmodule

// File: rtl/cop_host_bridge.sv
module cop_host_bridge #(
  parameter int HADDR_W = 13,
  parameter int DW      = 8,
  parameter int COP_W   = 16,
  parameter int RAM_AW  = 20,
  parameter int N_MB    = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [HADDR_W-1:0]      host_addr,
  input  logic                    host_wr,
  input  logic                    host_rd,
  input  logic [DW-1:0]           host_wdata,
  output logic [DW-1:0]           host_rdata,
  input  logic [$clog2(N_MB)-1:0] cop_mb_sel,
  input  logic                    cop_mb_we,
  input  logic [COP_W-1:0]        cop_mb_wdata,
  output logic [COP_W-1:0]        cop_mb_rdata,
  input  logic                    cop_ovl_we,
  input  logic                    cop_ovl_d,
  input  logic                    cop_irq_ack,
  output logic                    ram_we,
  output logic [RAM_AW-1:0]       ram_addr,
  output logic [DW-1:0]           ram_wdata,
  output logic                    cop_halt,
  output logic                    cop_reset,
  output logic                    cop_irq,
  output logic                    overlay_en
);
  import hb_pkg::*;
  localparam int MBW = $clog2(N_MB);

  logic          unlocked;
  logic          in_win, is_mb, is_alo, is_ahi, is_data, is_ctrl;
  logic          wr_ok;
  logic [DW-1:0] mb_rval;
  logic          own, ovl;

  always_comb begin
    in_win  = (host_addr[HADDR_W-1 -: 3] == WIN_TOP);
    is_mb   = (host_addr[HADDR_W-1:MBW] == OFF_MB0[HADDR_W-1:MBW]);
    is_alo  = (host_addr == OFF_ALO);
    is_ahi  = (host_addr == OFF_AHI);
    is_data = (host_addr == OFF_DATA);
    is_ctrl = (host_addr == OFF_CTRL);
    wr_ok   = host_wr && unlocked;
  end

  hb_unlock #(.KEY_LEN(KEY_LEN), .DW(DW)) u_unlock (
    .clk(clk), .rst(rst),
    .byte_we(host_wr && in_win), .byte_d(host_wdata),
    .unlocked(unlocked)
  );

  hb_mailbox #(.N(N_MB), .W(DW), .COP_W(COP_W)) u_mbox (
    .clk(clk), .rst(rst),
    .host_we(wr_ok && is_mb), .host_idx(host_addr[MBW-1:0]),
    .host_wdata(host_wdata), .host_rval(mb_rval),
    .cop_we(cop_mb_we), .cop_idx(cop_mb_sel),
    .cop_wdata(cop_mb_wdata), .cop_rdata(cop_mb_rdata)
  );

  hb_loader #(.AW(RAM_AW), .DW(DW)) u_loader (
    .clk(clk), .rst(rst),
    .stage_we(wr_ok && is_alo), .latch_we(wr_ok && is_ahi),
    .data_we(wr_ok && is_data), .own(own), .wdata(host_wdata),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
  );

  hb_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rst(rst),
    .host_we(wr_ok && is_ctrl), .wdata(host_wdata),
    .cop_ovl_we(cop_ovl_we), .cop_ovl_d(cop_ovl_d),
    .cop_irq_ack(cop_irq_ack),
    .own(own), .ovl(ovl), .cop_reset(cop_reset), .cop_irq(cop_irq)
  );

  assign cop_halt   = own;
  assign overlay_en = ovl;

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else begin
      host_rdata <= '0;
      if (host_rd && unlocked) begin
        if (is_mb)        host_rdata <= mb_rval;
        else if (is_ctrl) host_rdata <= {ovl, {(DW-2){1'b0}}, own};
      end
    end
  end
endmodule

// File: rtl/hb_checker.sv
module hb_checker #(
  parameter int DW     = 8,
  parameter int RAM_AW = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              host_wr,
  input logic [DW-1:0]     host_rdata,
  input logic              unlocked,
  input logic              cop_halt,
  input logic              cop_reset,
  input logic              cop_irq,
  input logic              cop_irq_ack,
  input logic              ram_we,
  input logic [RAM_AW-1:0] ram_addr
);
  // R2
  locked_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(unlocked) |-> host_rdata == '0);

  // R3
  unlock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    unlocked |=> unlocked);

  // R7
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    ram_we && $past(ram_we) |-> ram_addr == RAM_AW'($past(ram_addr) + 1'b1));

  // R8
  strobe_needs_own_chk: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> $past(cop_halt));

  // R9
  reset_pulse_src_chk: assert property (@(posedge clk) disable iff (rst)
    cop_reset && !$past(rst) |-> $past(host_wr && unlocked));

  // R10
  irq_clear_src_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cop_irq) |-> $past(cop_irq_ack));
endmodule

bind cop_host_bridge hb_checker #(.DW(DW), .RAM_AW(RAM_AW)) u_hb_checker (
  .clk(clk), .rst(rst), .host_wr(host_wr), .host_rdata(host_rdata),
  .unlocked(unlocked), .cop_halt(cop_halt), .cop_reset(cop_reset),
  .cop_irq(cop_irq), .cop_irq_ack(cop_irq_ack),
  .ram_we(ram_we), .ram_addr(ram_addr)
);

// File: tb/test_cop_host_bridge.sv
module test_cop_host_bridge;
  logic        clk = 0;
  logic        rst = 1;
  logic [12:0] host_addr = '0;
  logic        host_wr = 0, host_rd = 0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic [1:0]  cop_mb_sel = '0;
  logic        cop_mb_we = 0;
  logic [15:0] cop_mb_wdata = '0;
  logic [15:0] cop_mb_rdata;
  logic        cop_ovl_we = 0, cop_ovl_d = 0, cop_irq_ack = 0;
  logic        ram_we;
  logic [19:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic        cop_halt, cop_reset, cop_irq, overlay_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cop_host_bridge i_cop_host_bridge (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cop_mb_sel(cop_mb_sel), .cop_mb_we(cop_mb_we),
    .cop_mb_wdata(cop_mb_wdata), .cop_mb_rdata(cop_mb_rdata),
    .cop_ovl_we(cop_ovl_we), .cop_ovl_d(cop_ovl_d),
    .cop_irq_ack(cop_irq_ack), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .cop_halt(cop_halt), .cop_reset(cop_reset),
    .cop_irq(cop_irq), .overlay_en(overlay_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hw(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic hr(input logic [12:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    host_addr = a; host_rd = 1;
    @(negedge clk);
    host_rd = 0;
    chk(tag, host_rdata, exp);
  endtask

  task automatic cop_rd(input logic [1:0] s, input logic [15:0] exp, input string tag);
    @(negedge clk);
    cop_mb_sel = s;
    @(negedge clk);
    chk(tag, cop_mb_rdata, exp);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 halt in reset", cop_halt, 1);
    chk("R1 cop_reset in reset", cop_reset, 1);
    chk("R1 irq in reset", cop_irq, 0);
    chk("R1 overlay in reset", overlay_en, 0);
    chk("R1 ram_we in reset", ram_we, 0);
    rst = 0;
    @(negedge clk);
    chk("R1 cop_reset after release", cop_reset, 0);
    chk("R1 halt after release", cop_halt, 1);
  endtask

  task automatic t_locked;
    hw(13'h1FF7, 8'h84);
    chk("R2 irq while locked", cop_irq, 0);
    chk("R2 overlay while locked", overlay_en, 0);
    hw(13'h1FF0, 8'h99);
    hr(13'h1FF0, 8'h00, "R2 read while locked");
    cop_rd(2'd0, 16'h0000, "R2 mailbox untouched");
  endtask

  task automatic t_unlock;
    byte bad[8]  = '{8'h47, 8'h6E, 8'h31, 8'h14, 8'hB3, 8'hEB, 8'hEC, 8'h00};
    byte good[9] = '{8'h47, 8'h6E, 8'h47, 8'h6E, 8'h31, 8'h14, 8'hB3, 8'hEB, 8'hEC};
    foreach (bad[i]) hw(13'h1D00, bad[i]);
    hr(13'h1FF7, 8'h00, "R3 wrong last byte stays locked");
    foreach (good[i]) begin
      hw(13'h1C00 + 13'(i), good[i]);
      if (i == 4) hw(13'h0100, 8'h31);
    end
    hr(13'h1FF7, 8'h00, "R3 eight of nine not yet open");
    hw(13'h1FFF, 8'h2B);
    hr(13'h1FF7, 8'h01, "R3 unlocked control readback");
  endtask

  task automatic t_mailbox;
    hw(13'h1FF2, 8'hA5);
    cop_rd(2'd2, 16'h00A5, "R4 host to cop");
    @(negedge clk);
    cop_mb_sel = 2'd1; cop_mb_wdata = 16'h1234; cop_mb_we = 1;
    @(negedge clk);
    cop_mb_we = 0;
    hr(13'h1FF1, 8'h34, "R4 cop to host low byte");
    @(negedge clk);
    host_addr = 13'h1FF3; host_wdata = 8'h5A; host_wr = 1;
    cop_mb_sel = 2'd3; cop_mb_wdata = 16'h00C3; cop_mb_we = 1;
    @(negedge clk);
    host_wr = 0; cop_mb_we = 0;
    cop_rd(2'd3, 16'h005A, "R5 host wins collision");
  endtask

  task automatic t_loader;
    hw(13'h1FF4, 8'hCD);
    hw(13'h1FF5, 8'hAB);
    hw(13'h1FF6, 8'h11);
    chk("R7 strobe", ram_we, 1);
    chk("R6 latched address", ram_addr, 20'hABCD0);
    chk("R7 data", ram_wdata, 8'h11);
    @(negedge clk);
    chk("R7 strobe one cycle", ram_we, 0);
    hw(13'h1FF4, 8'h00);
    hw(13'h1FF6, 8'h22);
    chk("R6 stage alone keeps pointer", ram_addr, 20'hABCD1);
    hw(13'h1FF4, 8'hFF);
    hw(13'h1FF5, 8'hFF);
    for (int i = 0; i < 16; i++) hw(13'h1FF6, 8'(i));
    chk("R7 top address", ram_addr, 20'hFFFFF);
    hw(13'h1FF6, 8'h77);
    chk("R7 wrap address", ram_addr, 20'h00000);
  endtask

  task automatic t_own;
    hw(13'h1FF7, 8'h00);
    chk("R8 release halt", cop_halt, 0);
    hw(13'h1FF6, 8'h55);
    chk("R8 write ignored", ram_we, 0);
    hw(13'h1FF7, 8'h01);
    chk("R8 take halt", cop_halt, 1);
    hw(13'h1FF6, 8'h66);
    chk("R8 pointer not advanced", ram_addr, 20'h00001);
  endtask

  task automatic t_pulses;
    hw(13'h1FF7, 8'h03);
    chk("R9 reset pulse high", cop_reset, 1);
    @(negedge clk);
    chk("R9 reset pulse one cycle", cop_reset, 0);
    hw(13'h1FF7, 8'h05);
    chk("R10 irq set", cop_irq, 1);
    repeat (3) @(negedge clk);
    chk("R10 irq held", cop_irq, 1);
    @(negedge clk);
    host_addr = 13'h1FF7; host_wdata = 8'h05; host_wr = 1; cop_irq_ack = 1;
    @(negedge clk);
    host_wr = 0; cop_irq_ack = 0;
    chk("R10 set beats ack", cop_irq, 1);
    @(negedge clk);
    cop_irq_ack = 1;
    @(negedge clk);
    cop_irq_ack = 0;
    chk("R10 ack clears", cop_irq, 0);
  endtask

  task automatic t_overlay;
    hw(13'h1FF7, 8'h81);
    chk("R11 host sets overlay", overlay_en, 1);
    hr(13'h1FF7, 8'h81, "R11 control readback");
    @(negedge clk);
    cop_ovl_we = 1; cop_ovl_d = 0;
    @(negedge clk);
    cop_ovl_we = 0;
    chk("R11 cop clears overlay", overlay_en, 0);
    hr(13'h1FF7, 8'h01, "R11 shared bit readback");
    @(negedge clk);
    host_addr = 13'h1FF7; host_wdata = 8'h81; host_wr = 1;
    cop_ovl_we = 1; cop_ovl_d = 0;
    @(negedge clk);
    host_wr = 0; cop_ovl_we = 0;
    chk("R11 host wins overlay conflict", overlay_en, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_locked;
    t_unlock;
    t_mailbox;
    t_loader;
    t_own;
    t_pulses;
    t_overlay;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule